// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the arithmetic and logic datapath of a small register-based processor. On each cycle it can take one two-operand request: a 3-bit opcode plus a destination operand and a source operand. It can instead take a one-operand request: a 2-bit opcode plus a single register value. The block returns the result and a write-enable for the destination register, both combinational. The register file, operand selection and memory access are left to the surrounding core.

The block holds the four condition flags in its own register: carry, negative, zero and overflow. A flag-updating operation loads all four flags at the next rising clock edge. A third kind of request sets or clears one chosen flag. The current carry is fed back into the add, subtract and rotate paths. The flags are also driven out so that branch logic can read them.

Top module: `alu_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, all four flags clear to 0. The `flags` port bit order is [0]=C, [1]=N, [2]=Z, [3]=V.
- R2: Binary opcode 000 (add) gives `result` = dst + src + C, with `dst_we`=1. After the edge, C holds the carry out of bit 7.
- R3: Binary opcode 010 (subtract) gives `result` = dst − src − C, with `dst_we`=1. After the edge, C is 1 exactly when the unsigned subtraction underflowed.
- R4: Binary opcode 011 (compare) computes dst − src and ignores the current C. `result` shows that difference, `dst_we` is 0, and all four flags load as for a subtract.
- R5: Binary opcodes 100 (OR), 101 (XOR) and 110 (AND) give the bitwise result with `dst_we`=1, and they clear C and V.
- R6: Binary opcode 111 (bit test) computes dst AND src with `dst_we`=0, and loads the flags as AND does.
- R7: Binary opcode 001 (move) gives `result` = src with `dst_we`=1, and leaves all four flags unchanged.
- R8: Every flag-updating operation sets N to bit 7 of `result` and sets Z when `result` is zero.
- R9: V flags signed overflow. On add, V=1 when both operands have the same sign and the result's sign differs from it. On subtract or compare, V=1 when the operands differ in sign and the result's sign differs from dst.
- R10: Unary opcode 00 increments and 01 decrements, with `dst_we`=1. C takes the carry or borrow out of bit 7, and V flags a signed wrap (0x7F→0x80 on increment, 0x80→0x7F on decrement).
- R11: Unary opcode 10 rotates right through carry: old C goes into bit 7 and bit 0 goes into C. Unary opcode 11 shifts right arithmetically: bit 7 is kept and bit 0 goes into C. Both clear V.
- R12: A flag request with `fl_sel` (00 C, 01 N, 10 Z, 11 V) loads `fl_set` (1 set, 0 clear) into that one flag and leaves the other three flags as they were.
- R13: A binary request takes priority over a unary request, and a unary request takes priority over a flag request. With no request, `dst_we` is 0 and the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bin_valid | input | 1 | Binary request this cycle |
| bin_op | input | 3 | Binary opcode |
| dst_val | input | 8 | Destination operand (left-hand side) |
| src_val | input | 8 | Source operand |
| un_valid | input | 1 | Unary request this cycle |
| un_op | input | 2 | Unary opcode |
| un_val | input | 8 | Unary operand |
| fl_valid | input | 1 | Single-flag request this cycle |
| fl_set | input | 1 | Value to load into the chosen flag |
| fl_sel | input | 2 | Chosen flag |
| result | output | 8 | Combinational result |
| dst_we | output | 1 | Destination write-enable |
| flags | output | 4 | Flag register {V,Z,N,C} |

## Verification
Some properties are checked on every clocked cycle: compare and bit test never raise the write-enable, move and idle cycles leave the flags untouched, N and Z follow the result that was just computed, logic operations clear C and V, and a single-flag request lands in the chosen bit. The bench's directed scenarios are the only evidence for the actual arithmetic values. These include carry and borrow chaining, compare ignoring the carry, the signed-overflow corners, the rotate and shift bit movement, and the priority among requests that arrive together.

// File: rtl/alu_pkg.sv
// Shared encodings for the ALU: opcode enums and the flag record.
// Assumes flag bit order {V,Z,N,C} with C in bit 0.
package alu_pkg;
    localparam int unsigned NUM_FLAGS = 4;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_MOV = 3'b001,
        OP_SUB = 3'b010,
        OP_CMP = 3'b011,
        OP_OR  = 3'b100,
        OP_XOR = 3'b101,
        OP_AND = 3'b110,
        OP_BIT = 3'b111
    } bin_op_e;

    typedef enum logic [1:0] {
        UN_INC = 2'b00,
        UN_DEC = 2'b01,
        UN_RCR = 2'b10,
        UN_ASR = 2'b11
    } un_op_e;

    typedef struct packed {
        logic v;
        logic z;
        logic n;
        logic c;
    } flags_t;
endpackage

// File: rtl/alu_binary.sv
// Two-operand datapath: add/sub with carry chaining, compare, logic ops, move.
// Purely combinational. Assumes cin is the current carry flag.
// Reports whether the destination is written and whether the flags load.
module alu_binary
    import alu_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  bin_op_e             op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  logic                cin,
    output logic [DATA_W-1:0]   res,
    output logic                store,
    output logic                upd,
    output flags_t              fl
);
    localparam int unsigned MSB = DATA_W - 1;

    logic [DATA_W:0] add_x;
    logic [DATA_W:0] sub_x;
    logic            borrow_in;

    // Extended sum and difference; carry feeds add and subtract, never compare.
    always_comb begin
        borrow_in = (op == OP_SUB) & cin;
        add_x = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        sub_x = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, borrow_in};
    end

    // Select result, store/update controls and flag values per opcode.
    always_comb begin
        res   = a;
        store = 1'b1;
        upd   = 1'b1;
        fl    = '0;
        case (op)
            OP_ADD: begin
                res  = add_x[MSB:0];
                fl.c = add_x[DATA_W];
                fl.v = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
            end
            OP_SUB, OP_CMP: begin
                res   = sub_x[MSB:0];
                store = (op == OP_SUB);
                fl.c  = sub_x[DATA_W];
                fl.v  = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
            end
            OP_MOV: begin
                res = b;
                upd = 1'b0;
            end
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_AND: res = a & b;
            OP_BIT: begin
                res   = a & b;
                store = 1'b0;
            end
            default: res = a;
        endcase
        fl.n = res[MSB];
        fl.z = (res == '0);
    end
endmodule

// File: rtl/alu_unary.sv
// One-operand datapath: increment, decrement, rotate right through carry,
// arithmetic shift right. Combinational; cin is the current carry flag.
module alu_unary
    import alu_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  un_op_e              op,
    input  logic [DATA_W-1:0]   a,
    input  logic                cin,
    output logic [DATA_W-1:0]   res,
    output flags_t              fl
);
    localparam int unsigned MSB = DATA_W - 1;

    logic [DATA_W:0] inc_x;
    logic [DATA_W:0] dec_x;

    // Extended increment and decrement for carry/borrow out.
    always_comb begin
        inc_x = {1'b0, a} + {{DATA_W{1'b0}}, 1'b1};
        dec_x = {1'b0, a} - {{DATA_W{1'b0}}, 1'b1};
    end

    // Select result and flags per unary opcode.
    always_comb begin
        fl = '0;
        case (op)
            UN_INC: begin
                res  = inc_x[MSB:0];
                fl.c = inc_x[DATA_W];
                fl.v = ~a[MSB] & res[MSB];
            end
            UN_DEC: begin
                res  = dec_x[MSB:0];
                fl.c = dec_x[DATA_W];
                fl.v = a[MSB] & ~res[MSB];
            end
            UN_RCR: begin
                res  = {cin, a[MSB:1]};
                fl.c = a[0];
            end
            default: begin
                res  = {a[MSB], a[MSB:1]};
                fl.c = a[0];
            end
        endcase
        fl.n = res[MSB];
        fl.z = (res == '0);
    end
endmodule

// File: rtl/flag_reg.sv
// Condition flag register. A whole-word load wins over a single-bit load.
// Synchronous active-low reset clears every flag.
module flag_reg #(
    parameter int unsigned NUM_FLAGS = 4,
    parameter int unsigned SEL_W     = $clog2(NUM_FLAGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_all,
    input  logic [NUM_FLAGS-1:0]  all_d,
    input  logic                  load_one,
    input  logic                  one_val,
    input  logic [SEL_W-1:0]      one_sel,
    output logic [NUM_FLAGS-1:0]  q
);
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_bit
        // Per-flag storage: reset, whole-word load, or targeted set/clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (load_all)
                q[i] <= all_d[i];
            else if (load_one && (one_sel == SEL_W'(i)))
                q[i] <= one_val;
        end
    end
endmodule

// File: rtl/alu_core.sv
// Top of the ALU: arbitrates binary, unary and single-flag requests
// (binary > unary > flag), drives result and write-enable combinationally,
// and updates the flag register at the clock edge.
// Assumes at most one operation is meant per cycle; lower ones are dropped.
module alu_core
    import alu_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bin_valid,
    input  logic [2:0]            bin_op,
    input  logic [DATA_W-1:0]     dst_val,
    input  logic [DATA_W-1:0]     src_val,
    input  logic                  un_valid,
    input  logic [1:0]            un_op,
    input  logic [DATA_W-1:0]     un_val,
    input  logic                  fl_valid,
    input  logic                  fl_set,
    input  logic [1:0]            fl_sel,
    output logic [DATA_W-1:0]     result,
    output logic                  dst_we,
    output logic [NUM_FLAGS-1:0]  flags
);
    localparam int unsigned MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_res;
    logic              b_store;
    logic              b_upd;
    flags_t            b_fl;
    logic [DATA_W-1:0] u_res;
    flags_t            u_fl;
    flags_t            cur_fl;
    logic              ld_all;
    logic              ld_one;
    logic [NUM_FLAGS-1:0] next_fl;

    assign cur_fl = flags_t'(flags);

    alu_binary #(.DATA_W(DATA_W)) u_bin (
        .op    (bin_op_e'(bin_op)),
        .a     (dst_val),
        .b     (src_val),
        .cin   (cur_fl.c),
        .res   (b_res),
        .store (b_store),
        .upd   (b_upd),
        .fl    (b_fl)
    );

    alu_unary #(.DATA_W(DATA_W)) u_un (
        .op  (un_op_e'(un_op)),
        .a   (un_val),
        .cin (cur_fl.c),
        .res (u_res),
        .fl  (u_fl)
    );

    // Request arbitration and output selection.
    always_comb begin
        result  = '0;
        dst_we  = 1'b0;
        ld_all  = 1'b0;
        next_fl = '0;
        if (bin_valid) begin
            result  = b_res;
            dst_we  = b_store;
            ld_all  = b_upd;
            next_fl = b_fl;
        end else if (un_valid) begin
            result  = u_res;
            dst_we  = 1'b1;
            ld_all  = 1'b1;
            next_fl = u_fl;
        end
        ld_one = fl_valid & ~bin_valid & ~un_valid;
    end

    flag_reg #(.NUM_FLAGS(NUM_FLAGS)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_all (ld_all),
        .all_d    (next_fl),
        .load_one (ld_one),
        .one_val  (fl_set),
        .one_sel  (fl_sel),
        .q        (flags)
    );

    // Compare and bit test never write the destination (R4, R6).
    p_nostore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bin_valid && (bin_op == 3'b011 || bin_op == 3'b111) |-> !dst_we);

    // Move copies the source and keeps flags (R7).
    p_mov_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bin_valid && bin_op == 3'b001 |=> $stable(flags));

    // N and Z follow the computed result (R8).
    p_nz_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bin_valid && bin_op != 3'b001) || (!bin_valid && un_valid)
        |=> flags[2] == ($past(result) == '0) && flags[1] == $past(result[MSB]));

    // Logic opcodes clear C and V (R5).
    p_logic_cv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bin_valid && bin_op[2] |=> !flags[0] && !flags[3]);

    // Single-flag request lands in the selected bit (R12).
    p_flag_one_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fl_valid && !bin_valid && !un_valid |=> flags[$past(fl_sel)] == $past(fl_set));

    // Idle cycles write nothing and hold flags (R13).
    p_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !bin_valid && !un_valid && !fl_valid |=> $stable(flags));
endmodule

// File: tb/alu_core_tb.sv
`timescale 1ns/1ps
module alu_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bin_valid = 1'b0;
    logic [2:0] bin_op = '0;
    logic [7:0] dst_val = '0;
    logic [7:0] src_val = '0;
    logic       un_valid = 1'b0;
    logic [1:0] un_op = '0;
    logic [7:0] un_val = '0;
    logic       fl_valid = 1'b0;
    logic       fl_set = 1'b0;
    logic [1:0] fl_sel = '0;
    logic [7:0] result;
    logic       dst_we;
    logic [3:0] flags;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    alu_core u_dut (
        .clk(clk), .rst_n(rst_n),
        .bin_valid(bin_valid), .bin_op(bin_op), .dst_val(dst_val), .src_val(src_val),
        .un_valid(un_valid), .un_op(un_op), .un_val(un_val),
        .fl_valid(fl_valid), .fl_set(fl_set), .fl_sel(fl_sel),
        .result(result), .dst_we(dst_we), .flags(flags)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Binary step: check comb outputs, then flags after the edge. Flags as {V,Z,N,C}.
    task automatic bin_step(input string req, input logic [2:0] op, input logic [7:0] d, input logic [7:0] s,
                            input logic [7:0] er, input logic ew, input logic [3:0] ef);
        @(negedge clk);
        bin_valid = 1'b1; bin_op = op; dst_val = d; src_val = s;
        #1;
        chk(req, "result", result, er);
        chk(req, "dst_we", {7'b0, dst_we}, {7'b0, ew});
        @(negedge clk);
        bin_valid = 1'b0;
        chk(req, "flags", {4'b0, flags}, {4'b0, ef});
    endtask

    task automatic un_step(input string req, input logic [1:0] op, input logic [7:0] a,
                           input logic [7:0] er, input logic [3:0] ef);
        @(negedge clk);
        un_valid = 1'b1; un_op = op; un_val = a;
        #1;
        chk(req, "result", result, er);
        chk(req, "dst_we", {7'b0, dst_we}, 8'h01);
        @(negedge clk);
        un_valid = 1'b0;
        chk(req, "flags", {4'b0, flags}, {4'b0, ef});
    endtask

    task automatic flag_step(input string req, input logic v, input logic [1:0] sel, input logic [3:0] ef);
        @(negedge clk);
        fl_valid = 1'b1; fl_set = v; fl_sel = sel;
        #1;
        chk(req, "dst_we", {7'b0, dst_we}, 8'h00);
        @(negedge clk);
        fl_valid = 1'b0;
        chk(req, "flags", {4'b0, flags}, {4'b0, ef});
    endtask

    task automatic t_reset;
        @(negedge clk); @(negedge clk);
        chk("R1", "flags", {4'b0, flags}, 8'h00);
        chk("R1", "dst_we", {7'b0, dst_we}, 8'h00);
        rst_n = 1'b1;
    endtask

    task automatic t_add;
        flag_step("R12", 1'b1, 2'b00, 4'b0001);
        bin_step("R2", 3'b000, 8'h10, 8'h20, 8'h31, 1'b1, 4'b0000);
        bin_step("R2", 3'b000, 8'hFF, 8'h01, 8'h00, 1'b1, 4'b0101);
        bin_step("R9", 3'b000, 8'h7F, 8'h00, 8'h80, 1'b1, 4'b1010);
    endtask

    task automatic t_sub;
        bin_step("R3", 3'b010, 8'h05, 8'h07, 8'hFE, 1'b1, 4'b0011);
        bin_step("R3", 3'b010, 8'h10, 8'h01, 8'h0E, 1'b1, 4'b0000);
        bin_step("R9", 3'b010, 8'h80, 8'h01, 8'h7F, 1'b1, 4'b1000);
    endtask

    task automatic t_cmp;
        flag_step("R12", 1'b1, 2'b00, 4'b1001);
        bin_step("R4", 3'b011, 8'h33, 8'h33, 8'h00, 1'b0, 4'b0100);
        bin_step("R4", 3'b011, 8'h01, 8'h02, 8'hFF, 1'b0, 4'b0011);
    endtask

    task automatic t_logic;
        flag_step("R12", 1'b1, 2'b11, 4'b1011);
        bin_step("R5", 3'b100, 8'hF0, 8'h0F, 8'hFF, 1'b1, 4'b0010);
        bin_step("R5", 3'b101, 8'hAA, 8'hAA, 8'h00, 1'b1, 4'b0100);
        bin_step("R5", 3'b110, 8'hC3, 8'h81, 8'h81, 1'b1, 4'b0010);
    endtask

    task automatic t_bit;
        bin_step("R6", 3'b111, 8'h0F, 8'hF0, 8'h00, 1'b0, 4'b0100);
    endtask

    task automatic t_mov;
        bin_step("R7", 3'b001, 8'h00, 8'h5A, 8'h5A, 1'b1, 4'b0100);
    endtask

    task automatic t_incdec;
        un_step("R10", 2'b00, 8'hFF, 8'h00, 4'b0101);
        un_step("R10", 2'b00, 8'h7F, 8'h80, 4'b1010);
        un_step("R10", 2'b01, 8'h00, 8'hFF, 4'b0011);
        un_step("R10", 2'b01, 8'h80, 8'h7F, 4'b1000);
    endtask

    task automatic t_shift;
        flag_step("R12", 1'b1, 2'b00, 4'b1001);
        un_step("R11", 2'b10, 8'h02, 8'h81, 4'b0010);
        un_step("R11", 2'b10, 8'h01, 8'h00, 4'b0101);
        un_step("R11", 2'b11, 8'h81, 8'hC0, 4'b0011);
        un_step("R11", 2'b11, 8'h02, 8'h01, 4'b0000);
    endtask

    task automatic t_flagop;
        flag_step("R12", 1'b1, 2'b01, 4'b0010);
        flag_step("R12", 1'b1, 2'b10, 4'b0110);
        flag_step("R12", 1'b1, 2'b11, 4'b1110);
        flag_step("R12", 1'b1, 2'b00, 4'b1111);
        flag_step("R12", 1'b0, 2'b01, 4'b1101);
    endtask

    task automatic t_priority;
        // Binary and unary together: binary add with C=1 wins.
        @(negedge clk);
        bin_valid = 1'b1; bin_op = 3'b000; dst_val = 8'h01; src_val = 8'h01;
        un_valid = 1'b1; un_op = 2'b00; un_val = 8'h10;
        #1;
        chk("R13", "result", result, 8'h03);
        @(negedge clk);
        bin_valid = 1'b0; un_valid = 1'b0;
        chk("R13", "flags", {4'b0, flags}, 8'h00);
        // Unary and flag request together: unary wins, V stays clear.
        @(negedge clk);
        un_valid = 1'b1; un_op = 2'b00; un_val = 8'h00;
        fl_valid = 1'b1; fl_set = 1'b1; fl_sel = 2'b11;
        #1;
        chk("R13", "result", result, 8'h01);
        @(negedge clk);
        un_valid = 1'b0; fl_valid = 1'b0;
        chk("R13", "flags", {4'b0, flags}, 8'h00);
        // Idle: no write, flags hold.
        flag_step("R12", 1'b1, 2'b01, 4'b0010);
        @(negedge clk);
        chk("R13", "dst_we", {7'b0, dst_we}, 8'h00);
        @(negedge clk);
        chk("R13", "flags", {4'b0, flags}, 8'h02);
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_cmp();
        t_logic();
        t_bit();
        t_mov();
        t_incdec();
        t_shift();
        t_flagop();
        t_priority();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule